// File: doc/BRIEF.md
# System Clock Prescaler and Machine-Cycle Generator

This block sets the timing for a small microcontroller core. It takes two oscillator sources, an external high-speed clock and an internal ring oscillator. Each source arrives as a one-cycle tick on the single core clock. A 4-bit mode word picks the source and a divide ratio of 1, 2, 4 or 8. A control bit gates the internal oscillator. The block produces a one-cycle system strobe `sys_stb` at the divided rate. A machine-cycle strobe `mc_stb` marks every third system strobe, which is the instruction rate.

The design uses clock enables throughout and generates no clocks. A small state machine holds the active configuration. In state ST_RUN the prescaler counts source ticks. In state ST_HALT the internal source is selected with its oscillator gated off, so nothing counts.

A new request is applied when the state machine takes a transition:
- ST_RUN→ST_RUN or ST_RUN→ST_HALT happens on a cycle where `sys_stb` is high.
- ST_HALT→ST_RUN or ST_HALT→ST_HALT happens on the first cycle the request differs.

Each application clears the prescaler and the machine-cycle counter. Reset enters ST_RUN with the internal source divided by 8.

Top module: `sysclk_gen`

## Requirements
- R1: While `rst_n` is low both strobes are low. After release the block runs from `int_tick` divided by 8, whatever `ext_tick` does.
- R2: `mode_cfg[0]` selects the source: 1 counts `int_tick`, 0 counts `ext_tick`.
- R3: `mode_cfg[3:2]` selects the ratio (00 = 1, 01 = 2, 10 = 4, 11 = 8). `sys_stb` is high for one cycle, the cycle after every Nth counted source tick.
- R4: `mc_stb` is high only together with `sys_stb`, on every third system strobe, counted from reset or from the last configuration change.
- R5: A new `mode_cfg`/`osc_off` value does not change the interval in progress. It is applied on the cycle where `sys_stb` is high. A source tick in that cycle is not counted. Both counters restart, so the first `mc_stb` under the new setting is on the third system strobe after the switch.
- R6: `mode_cfg[1]` is reserved. Changing it causes no restart and no change in strobe spacing.
- R7: With the internal source selected and `osc_off` = 1, no strobes are produced after the switching boundary. Clearing `osc_off` resumes counting on the next cycle, without waiting for a strobe.
- R8: With the external source selected, `osc_off` has no effect: no restart and no change in spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_tick | input | 1 | One-cycle tick from the external high-speed source |
| int_tick | input | 1 | One-cycle tick from the internal ring oscillator |
| mode_cfg | input | 4 | [3:2] ratio, [1] reserved, [0] source select |
| osc_off | input | 1 | 1 gates off the internal oscillator |
| sys_stb | output | 1 | System clock enable strobe |
| mc_stb | output | 1 | Machine-cycle strobe |

## Verification
Most wrong internal states show up as a changed `sys_stb` spacing:
- A bad ratio decode, source mux or prescaler limit shows at the first interval after the configuration settles, within eight source ticks.
- A switch applied off the boundary shortens or lengthens the interval in progress.

A machine-cycle counter that is not cleared or wraps wrongly moves `mc_stb` off every third strobe. That shows within three system strobes. A spurious restart, triggered by the reserved bit or by `osc_off` in external mode, stretches one machine cycle. A stuck halt state shows as missing strobes.

// File: rtl/sysclk_gen_pkg.sv
`timescale 1ns/1ps
package sysclk_gen_pkg;

    parameter int RATIO_SEL_W = 2;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } clk_src_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic [RATIO_SEL_W-1:0] ratio;
        clk_src_e               src;
        logic                   osc_off;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_AFTER_RESET = '{
        ratio:   {RATIO_SEL_W{1'b1}},
        src:     SRC_INT,
        osc_off: 1'b0
    };

    // Build the normalised request: reserved bit dropped, gate bit only
    // meaningful for the internal source.
    function automatic clk_cfg_t decode_cfg(input logic [3:0] mode,
                                            input logic       gate_off);
        clk_cfg_t c;
        c.ratio   = mode[3:2];
        c.src     = mode[0] ? SRC_INT : SRC_EXT;
        c.osc_off = mode[0] & gate_off;
        return c;
    endfunction

    function automatic logic cfg_halts(input clk_cfg_t c);
        return (c.src == SRC_INT) && c.osc_off;
    endfunction

endpackage

// File: rtl/sysclk_src_mux.sv
`timescale 1ns/1ps
module sysclk_src_mux
    import sysclk_gen_pkg::*;
(
    input  logic     ext_tick,
    input  logic     int_tick,
    input  clk_src_e src,
    input  logic     osc_off,
    output logic     src_tick
);

    always_comb begin
        unique case (src)
            SRC_INT: src_tick = int_tick & ~osc_off;
            SRC_EXT: src_tick = ext_tick;
            default: src_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/sysclk_prescaler.sv
`timescale 1ns/1ps
module sysclk_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] ratio,
    output logic             wrap,
    output logic             stb
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // ratio k divides by 2**k: terminal count is 2**k - 1
    always_comb begin
        limit = ~({CNT_W{1'b1}} << ratio);
        wrap  = count_en && tick && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            stb   <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= wrap;
            if (count_en && tick) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysclk_cycle_div.sv
`timescale 1ns/1ps
module sysclk_cycle_div #(
    parameter int RATIO = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic mc_stb
);

    localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    logic [PH_W-1:0] phase_q;
    logic            last;

    always_comb last = (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mc_stb  <= 1'b0;
        end else if (clr) begin
            phase_q <= '0;
            mc_stb  <= 1'b0;
        end else begin
            mc_stb <= adv && last;
            if (adv) begin
                phase_q <= last ? '0 : phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysclk_gen.sv
`timescale 1ns/1ps
module sysclk_gen
    import sysclk_gen_pkg::*;
#(
    parameter int MC_RATIO = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_tick,
    input  logic       int_tick,
    input  logic [3:0] mode_cfg,
    input  logic       osc_off,
    output logic       sys_stb,
    output logic       mc_stb
);

    gen_state_e state_q, state_d;
    clk_cfg_t   cfg_q, req_cfg;
    logic       cfg_diff;
    logic       cfg_apply;
    logic       count_en;
    logic       halted;
    logic       src_tick;
    logic       pre_wrap;
    logic [3:0] cfg_bits;

    always_comb begin
        req_cfg  = decode_cfg(mode_cfg, osc_off);
        cfg_diff = (req_cfg != cfg_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sys_stb && cfg_diff) begin
                    state_d = cfg_halts(req_cfg) ? ST_HALT : ST_RUN;
                end
            end
            ST_HALT: begin
                if (cfg_diff) begin
                    state_d = cfg_halts(req_cfg) ? ST_HALT : ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state and active configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cfg_q   <= CFG_AFTER_RESET;
        end else begin
            state_q <= state_d;
            if (cfg_apply) begin
                cfg_q <= req_cfg;
            end
        end
    end

    // per-state outputs
    always_comb begin
        cfg_apply = 1'b0;
        count_en  = 1'b0;
        halted    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cfg_apply = sys_stb && cfg_diff;
                count_en  = !cfg_apply;
            end
            ST_HALT: begin
                cfg_apply = cfg_diff;
                halted    = 1'b1;
            end
            default: ;
        endcase
    end

    assign cfg_bits = cfg_q;

    sysclk_src_mux u_mux (
        .ext_tick (ext_tick),
        .int_tick (int_tick),
        .src      (cfg_q.src),
        .osc_off  (cfg_q.osc_off),
        .src_tick (src_tick)
    );

    sysclk_prescaler #(
        .SEL_W (RATIO_SEL_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .clr      (cfg_apply),
        .tick     (src_tick),
        .ratio    (cfg_q.ratio),
        .wrap     (pre_wrap),
        .stb      (sys_stb)
    );

    sysclk_cycle_div #(
        .RATIO (MC_RATIO)
    ) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_apply),
        .adv    (pre_wrap),
        .mc_stb (mc_stb)
    );

endmodule

// File: rtl/sysclk_gen_chk.sv
`timescale 1ns/1ps
module sysclk_gen_chk #(
    parameter int MC_RATIO = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_stb,
    input logic       mc_stb,
    input logic       halted,
    input logic       apply,
    input logic [3:0] cfg_bits
);

    localparam int SEEN_W = (MC_RATIO > 2) ? $clog2(MC_RATIO) + 1 : 2;

    logic [SEEN_W-1:0] seen_q;

    // system strobes seen since reset, last machine-cycle strobe or switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (apply || mc_stb) begin
            seen_q <= '0;
        end else if (sys_stb) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_reset_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cfg_bits == 4'b1110);

    assert_mc_with_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |-> sys_stb);

    assert_mc_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |-> seen_q == SEEN_W'(MC_RATIO - 1));

    assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_stb && !mc_stb) |-> seen_q < SEEN_W'(MC_RATIO - 1));

    assert_switch_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bits) |-> ($past(sys_stb) || $past(halted)));

    assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !sys_stb);

endmodule

bind sysclk_gen sysclk_gen_chk #(
    .MC_RATIO (MC_RATIO)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_stb  (sys_stb),
    .mc_stb   (mc_stb),
    .halted   (halted),
    .apply    (cfg_apply),
    .cfg_bits (cfg_bits)
);

// File: tb/sysclk_gen_tb.sv
`timescale 1ns/1ps
module sysclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_tick = 1'b0;
    logic       int_tick = 1'b0;
    logic [3:0] mode_cfg = 4'b1101;
    logic       osc_off = 1'b0;
    logic       sys_stb;
    logic       mc_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int int_per = 1;
    int ext_per = 2;
    bit finished = 1'b0;

    sysclk_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_tick (ext_tick),
        .int_tick (int_tick),
        .mode_cfg (mode_cfg),
        .osc_off  (osc_off),
        .sys_stb  (sys_stb),
        .mc_stb   (mc_stb)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // oscillator tick generators, driven away from the active edge
    initial begin
        int ic;
        int ec;
        ic = 0;
        ec = 0;
        forever begin
            @(negedge clk);
            ic = (ic + 1 >= int_per) ? 0 : ic + 1;
            ec = (ec + 1 >= ext_per) ? 0 : ec + 1;
            int_tick = (ic == 0);
            ext_tick = (ec == 0);
        end
    end

    task automatic check_eq(input string req, input string what,
                            input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_stb(output int t, output bit mc);
        t = -1;
        mc = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (sys_stb) begin
                t = cyc;
                mc = mc_stb;
                return;
            end
        end
    endtask

    task automatic wait_mc(output int t);
        bit m;
        int tt;
        t = -1;
        for (int i = 0; i < 64; i++) begin
            wait_stb(tt, m);
            if (tt < 0) return;
            if (m) begin
                t = tt;
                return;
            end
        end
    endtask

    task automatic settle();
        int t;
        bit m;
        wait_stb(t, m);
        wait_stb(t, m);
    endtask

    task automatic meas_sys(input int exp, input string req, input int n);
        int t0;
        int t1;
        bit m;
        wait_stb(t0, m);
        for (int i = 0; i < n; i++) begin
            wait_stb(t1, m);
            check_eq(req, "sys_stb interval", t1 - t0, exp);
            t0 = t1;
        end
    endtask

    task automatic meas_mc(input int exp, input string req, input int n);
        int t0;
        int t1;
        wait_mc(t0);
        for (int i = 0; i < n; i++) begin
            wait_mc(t1);
            check_eq(req, "mc_stb interval", t1 - t0, exp);
            t0 = t1;
        end
    endtask

    // R1: quiet in reset, internal source /8 after release
    task automatic t_reset();
        int hi;
        hi = 0;
        int_per = 1;
        ext_per = 3;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sys_stb || mc_stb) hi++;
        end
        check_eq("R1", "strobes during reset", hi, 0);
        rst_n = 1'b1;
        meas_sys(8, "R1", 3);
        meas_mc(24, "R4", 2);
    endtask

    // R2, R3: external source at every ratio, internal at one ratio
    task automatic t_ratios();
        int_per = 1;
        ext_per = 2;
        for (int r = 0; r < 4; r++) begin
            mode_cfg = {r[1:0], 2'b00};
            settle();
            meas_sys(2 * (1 << r), "R3", 3);
        end
        meas_mc(3 * 16, "R4", 1);
        int_per = 3;
        mode_cfg = 4'b0101;
        settle();
        meas_sys(6, "R2", 3);
        meas_mc(18, "R4", 2);
    endtask

    // R5: switch waits for the boundary, counters restart
    task automatic t_switch();
        int t0;
        int t1;
        bit m;
        int_per = 1;
        ext_per = 2;
        mode_cfg = 4'b1101;
        settle();
        wait_stb(t0, m);
        repeat (2) @(negedge clk);
        mode_cfg = 4'b0000;
        wait_stb(t1, m);
        check_eq("R5", "interval in progress", t1 - t0, 8);
        wait_stb(t1, m);
        check_eq("R5", "mc on 1st strobe after switch", int'(m), 0);
        wait_stb(t1, m);
        check_eq("R5", "mc on 2nd strobe after switch", int'(m), 0);
        wait_stb(t1, m);
        check_eq("R5", "mc on 3rd strobe after switch", int'(m), 1);
        meas_sys(2, "R5", 2);
    endtask

    // R6: reserved bit causes no restart
    task automatic t_reserved();
        int t0;
        int t1;
        int_per = 1;
        mode_cfg = 4'b0101;
        settle();
        wait_mc(t0);
        mode_cfg = 4'b0111;
        for (int i = 0; i < 3; i++) begin
            wait_mc(t1);
            check_eq("R6", "mc interval after reserved toggle", t1 - t0, 6);
            t0 = t1;
        end
        mode_cfg = 4'b0101;
        wait_mc(t1);
        check_eq("R6", "mc interval after reserved clear", t1 - t0, 6);
    endtask

    // R8: gate bit ignored with external source
    task automatic t_gate_dc();
        int t0;
        int t1;
        ext_per = 2;
        mode_cfg = 4'b0100;
        settle();
        wait_mc(t0);
        osc_off = 1'b1;
        for (int i = 0; i < 2; i++) begin
            wait_mc(t1);
            check_eq("R8", "mc interval with gate set", t1 - t0, 12);
            t0 = t1;
        end
        osc_off = 1'b0;
        wait_mc(t1);
        check_eq("R8", "mc interval with gate cleared", t1 - t0, 12);
    endtask

    // R7: gated internal source halts, clearing resumes promptly
    task automatic t_halt();
        int hi;
        int trel;
        int t;
        bit m;
        int_per = 1;
        mode_cfg = 4'b0101;
        settle();
        osc_off = 1'b1;
        repeat (10) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sys_stb || mc_stb) hi++;
        end
        check_eq("R7", "strobes while halted", hi, 0);
        osc_off = 1'b0;
        trel = cyc;
        wait_stb(t, m);
        check_eq("R7", "resume within 4 cycles", int'(t >= 0 && t - trel <= 4), 1);
        meas_sys(2, "R7", 2);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ratios();
        t_switch();
        t_reserved();
        t_gate_dc();
        t_halt();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule